// File: doc/BRIEF.md
# Serial Instruction Slave with Status Return

This block is the serial front end of a radio core. A host drives an active-low select, a serial clock and a data line into it, and reads one data line back. Bytes arrive most significant bit first and are captured on rising serial clock edges. Each finished byte crosses into the system clock domain and appears there as a one-cycle strobe. A flag on that strobe marks whether the byte opens a new instruction.

The block decides where each instruction ends. The opcode byte selects either a fixed length of one to four bytes, or an open length that lasts until the select line rises. While the first and second bytes of an instruction shift in, the return line shifts out a status byte. The top bit of that byte is the oscillator-ready flag. Once select falls and before any clock edge, the return line shows that flag directly through logic, with no register between.

Raising select clears all serial-side state at once, with no clock needed. The host may stop the serial clock for any length of time in the middle of a byte.

Top module: `spi_instr_slave`

## Requirements
- R1: When select is high, `miso` is 0. When select is low and no falling serial clock edge has occurred since select fell, `miso` equals `xoscStable` and follows it combinationally.
- R2: Every eight rising `sclk` edges with select low form one byte, taken from `mosi` with the most significant bit first. That byte appears on `byteData`, in the order it was received, together with a `byteValid` strobe.
- R3: `byteFirst` is 1 with a byte exactly when that byte is the first byte of an instruction.
- R4: The length of an instruction is decoded from bits 7:5 of its first byte: 000 gives 1 byte, 001 gives 2, 010 gives 3 and 011 gives 4. When bit 7 is 1, the instruction is open and ends only when select rises.
- R5: After the last byte of a fixed-length instruction, the next byte with select still low starts a new instruction.
- R6: During byte 0 and byte 1 of an instruction, `miso` carries the status word {`xoscStable`, `statusIn[6:0]`}, most significant bit first. A new bit is launched on each falling `sclk` edge. `statusIn` is taken at the byte's first rising edge. During byte 2 and any later byte, `miso` is 0.
- R7: Stopping `sclk` for any length of time inside a byte, with select low, neither loses nor shifts bit positions.
- R8: Raising select discards a partly received byte and ends the current instruction. The next byte after select falls again is a first byte.
- R9: Each byte produces exactly one `byteValid` pulse lasting one `clk` cycle. The pulse comes no more than 4 `clk` cycles after the byte's eighth rising `sclk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset for the handoff logic |
| csN | input | 1 | Active-low select; when high it resets the serial side asynchronously |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host, sampled on rising `sclk` |
| miso | output | 1 | Serial data to the host: the status word or the oscillator-ready flag |
| xoscStable | input | 1 | Oscillator-ready flag, used as status bit 7 |
| statusIn | input | 7 | Lower seven status bits |
| byteValid | output | 1 | One-cycle strobe in the `clk` domain for each received byte |
| byteData | output | 8 | Received byte, held until the next strobe |
| byteFirst | output | 1 | Set when the byte is the first byte of an instruction |

## Verification
The assertions take several things about the inputs for granted. Select rests low for more than two `clk` periods around each burst of `sclk` edges. Each byte lasts several `clk` cycles, so a held byte is read before it is overwritten. `statusIn` and `xoscStable` change only while `sclk` is low between bytes. The stimulus meets all of these. It drives every `sclk` edge on a falling `clk` edge, holds each serial clock phase for eight system cycles, and changes status only between bytes. It also changes `xoscStable` only while select is high or before the first edge.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

  localparam int BYTE_W = 8;
  localparam int BIT_W  = $clog2(BYTE_W);
  localparam int IDX_W  = 2;
  localparam int LEN_W  = 3;

  typedef struct packed {
    logic             byteDone;
    logic             firstOfInstr;
    logic             inWindow;
    logic [BIT_W-1:0] bitPos;
  } ctlStrobe_t;

  // Length of an instruction from its opcode: 0 means open (ends when select rises).
  function automatic logic [LEN_W-1:0] instrLen(input logic [BYTE_W-1:0] op);
    logic [LEN_W-1:0] len;
    case (op[BYTE_W-1 -: 3])
      3'b000:  len = LEN_W'(1);
      3'b001:  len = LEN_W'(2);
      3'b010:  len = LEN_W'(3);
      3'b011:  len = LEN_W'(4);
      default: len = '0;
    endcase
    return len;
  endfunction

endpackage

// File: rtl/spi_slv_ctrl.sv
module spi_slv_ctrl
  import spi_slv_pkg::*;
(
  input  logic              sclk,
  input  logic              csN,
  input  logic [BYTE_W-1:0] rxByteNow,
  output ctlStrobe_t        strobe
);

  logic [BIT_W-1:0] bitCnt;
  logic [IDX_W-1:0] byteIdx;
  logic [LEN_W-1:0] lenReg;
  logic [LEN_W-1:0] lenNow;
  logic             byteDone;
  logic             lastByte;

  assign byteDone = (bitCnt == BIT_W'(BYTE_W - 1));
  assign lenNow   = (byteIdx == '0) ? instrLen(rxByteNow) : lenReg;
  assign lastByte = (lenNow != '0) && ((LEN_W'(byteIdx) + LEN_W'(1)) == lenNow);

  always_ff @(posedge sclk or posedge csN) begin
    if (csN) begin
      bitCnt  <= '0;
      byteIdx <= '0;
      lenReg  <= '0;
    end else begin
      bitCnt <= byteDone ? '0 : bitCnt + BIT_W'(1);
      if (byteDone) begin
        if (byteIdx == '0) lenReg <= lenNow;
        if (lastByte)               byteIdx <= '0;
        else if (byteIdx != '1)     byteIdx <= byteIdx + IDX_W'(1);
      end
    end
  end

  always_comb begin
    strobe.byteDone     = byteDone;
    strobe.firstOfInstr = (byteIdx == '0);
    strobe.inWindow     = (byteIdx <= IDX_W'(1));
    strobe.bitPos       = bitCnt;
  end

  // R5: a fixed-length instruction wraps to a new first byte
  p_wrap_r5: assert property (@(posedge sclk) disable iff (csN)
    (byteDone && lastByte) |=> (byteIdx == '0));

  // R4: an opcode with bit 7 set is recorded as open-ended
  p_open_r4: assert property (@(posedge sclk) disable iff (csN)
    (byteDone && byteIdx == '0 && rxByteNow[BYTE_W-1]) |=> (lenReg == '0));

endmodule

// File: rtl/spi_slv_dpath.sv
module spi_slv_dpath
  import spi_slv_pkg::*;
(
  input  logic              sclk,
  input  logic              csN,
  input  logic              rstN,
  input  logic              mosi,
  input  logic              xoscStable,
  input  logic [BYTE_W-2:0] statusIn,
  input  ctlStrobe_t        strobe,
  output logic [BYTE_W-1:0] rxByteNow,
  output logic              miso,
  output logic [BYTE_W-1:0] holdByte,
  output logic              holdFirst,
  output logic              xferToggle
);

  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-2:0] statusSnap;
  logic [BYTE_W-1:0] outWord;
  logic [BIT_W-1:0]  snapIdx;
  logic              outBit;
  logic              launched;

  assign rxByteNow = {rxShift[BYTE_W-2:0], mosi};
  assign outWord   = {xoscStable, statusSnap};
  assign snapIdx   = BIT_W'(BYTE_W - 1) - strobe.bitPos;

  // Capture side: rising serial clock edges.
  always_ff @(posedge sclk or posedge csN) begin
    if (csN) begin
      rxShift    <= '0;
      statusSnap <= '0;
    end else begin
      rxShift <= rxByteNow;
      if (strobe.bitPos == '0) statusSnap <= statusIn;
    end
  end

  // Launch side: falling serial clock edges.
  always_ff @(negedge sclk or posedge csN) begin
    if (csN) begin
      outBit   <= 1'b0;
      launched <= 1'b0;
    end else begin
      launched <= 1'b1;
      outBit   <= strobe.inWindow ? outWord[snapIdx] : 1'b0;
    end
  end

  always_comb begin
    if (csN)            miso = 1'b0;
    else if (!launched) miso = xoscStable;
    else                miso = outBit;
  end

  // Handoff registers: not cleared by select, so no false toggle appears.
  always_ff @(posedge sclk or negedge rstN) begin
    if (!rstN) begin
      holdByte   <= '0;
      holdFirst  <= 1'b0;
      xferToggle <= 1'b0;
    end else if (strobe.byteDone) begin
      holdByte   <= rxByteNow;
      holdFirst  <= strobe.firstOfInstr;
      xferToggle <= ~xferToggle;
    end
  end

endmodule

// File: rtl/spi_slv_sync.sv
module spi_slv_sync
  import spi_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferToggle,
  input  logic [BYTE_W-1:0] holdByte,
  input  logic              holdFirst,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteFirst
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic                   edgeSeen;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       syncQ[g] <= 1'b0;
      else if (g == 0) syncQ[g] <= xferToggle;
      else             syncQ[g] <= syncQ[(g == 0) ? 0 : g - 1];
    end
  end

  assign edgeSeen = syncQ[SYNC_STAGES-1] ^ prevQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ     <= 1'b0;
      byteValid <= 1'b0;
      byteData  <= '0;
      byteFirst <= 1'b0;
    end else begin
      prevQ     <= syncQ[SYNC_STAGES-1];
      byteValid <= edgeSeen;
      if (edgeSeen) begin
        byteData  <= holdByte;
        byteFirst <= holdFirst;
      end
    end
  end

  // R9: the strobe lasts a single system cycle
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |=> !byteValid);

  // R2: delivered data only changes together with a strobe
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> $stable(byteData));

endmodule

// File: rtl/spi_instr_slave.sv
module spi_instr_slave
  import spi_slv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              mosi,
  output logic              miso,
  input  logic              xoscStable,
  input  logic [BYTE_W-2:0] statusIn,
  output logic              byteValid,
  output logic [BYTE_W-1:0] byteData,
  output logic              byteFirst
);

  ctlStrobe_t        strobe;
  logic [BYTE_W-1:0] rxByteNow;
  logic [BYTE_W-1:0] holdByte;
  logic              holdFirst;
  logic              xferToggle;

  spi_slv_ctrl u_ctrl (
    .sclk      (sclk),
    .csN       (csN),
    .rxByteNow (rxByteNow),
    .strobe    (strobe)
  );

  spi_slv_dpath u_dpath (
    .sclk       (sclk),
    .csN        (csN),
    .rstN       (rstN),
    .mosi       (mosi),
    .xoscStable (xoscStable),
    .statusIn   (statusIn),
    .strobe     (strobe),
    .rxByteNow  (rxByteNow),
    .miso       (miso),
    .holdByte   (holdByte),
    .holdFirst  (holdFirst),
    .xferToggle (xferToggle)
  );

  spi_slv_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rstN       (rstN),
    .xferToggle (xferToggle),
    .holdByte   (holdByte),
    .holdFirst  (holdFirst),
    .byteValid  (byteValid),
    .byteData   (byteData),
    .byteFirst  (byteFirst)
  );

  // R6: bytes past the status window shift out zeros
  p_tail_r6: assert property (@(posedge sclk) disable iff (csN)
    (!strobe.inWindow && strobe.bitPos != '0) |-> !miso);

endmodule

// File: tb/spi_instr_slave_test.sv
module spi_instr_slave_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic       mosi = 1'b0;
  logic       xoscStable = 1'b0;
  logic [6:0] statusIn = '0;
  logic       miso;
  logic       byteValid;
  logic [7:0] byteData;
  logic       byteFirst;

  spi_instr_slave uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .xoscStable(xoscStable), .statusIn(statusIn),
    .byteValid(byteValid), .byteData(byteData), .byteFirst(byteFirst)
  );

  always #4 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  bit done = 0;
  bit monOn = 0;
  bit prevValid = 0;

  // Behavioural reference model of instruction framing
  int mIdx = 0;
  int mLen = 0;
  logic [8:0] expQ[$];
  int expCyc[$];

  always @(posedge clk) cyc++;

  function automatic int lenOf(input logic [7:0] op);
    if (op < 8'd32) return 1;
    if (op < 8'd64) return 2;
    if (op < 8'd96) return 3;
    if (op < 8'd128) return 4;
    return 0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Per-clock comparison of delivered bytes against the model queue
  always @(negedge clk) begin
    if (monOn) begin
      if (byteValid) begin
        check(!prevValid, "R9", "strobe longer than one cycle", 1, 0);
        if (expQ.size() == 0) begin
          check(1'b0, "R2", "unexpected byte", int'(byteData), -1);
        end else begin
          logic [8:0] e;
          int pc;
          e = expQ.pop_front();
          pc = expCyc.pop_front();
          check(byteData == e[7:0], "R2", "byte value", int'(byteData), int'(e[7:0]));
          check(byteFirst == e[8], "R3 R5", "first flag", int'(byteFirst), int'(e[8]));
          check((cyc - pc) <= 4, "R9", "strobe latency", cyc - pc, 4);
        end
      end else begin
        check(expQ.size() == 0 || (cyc - expCyc[0]) <= 4, "R9", "byte missing",
              expQ.size(), 0);
      end
      prevValid = byteValid;
    end
  end

  task automatic csLow();
    csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (4) @(negedge clk);
    csN = 1'b1;
    mIdx = 0;
    repeat (4) @(negedge clk);
  endtask

  // Shift nBits of tx; pauseAt holds sclk low before that bit (R7)
  task automatic sendByte(input logic [7:0] tx, input int nBits, input int pauseAt);
    logic [7:0] expWord;
    expWord = (mIdx <= 1) ? {xoscStable, statusIn} : 8'h00;
    for (int b = 0; b < nBits; b++) begin
      mosi = tx[7-b];
      repeat (8) @(negedge clk);
      if (b == pauseAt) repeat (300) @(negedge clk);
      check(miso === expWord[7-b], "R6", "miso bit", int'(miso), int'(expWord[7-b]));
      sclk = 1'b1;
      if (b == 7) begin
        expQ.push_back({(mIdx == 0), tx});
        expCyc.push_back(cyc);
        if (mIdx == 0) mLen = lenOf(tx);
        mIdx++;
        if (mLen != 0 && mIdx == mLen) mIdx = 0;
      end
      repeat (8) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(byteValid == 1'b0, "R9", "reset strobe", int'(byteValid), 0);
    check(miso == 1'b0, "R1", "miso deselected in reset", int'(miso), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    monOn = 1;

    // R1: comb oscillator flag before any edge
    csN = 1'b0;
    #1 check(miso == 1'b0, "R1", "miso shows flag low", int'(miso), 0);
    xoscStable = 1'b1;
    #1 check(miso == 1'b1, "R1", "miso follows flag", int'(miso), 1);
    @(negedge clk);
    csN = 1'b1;
    #1 check(miso == 1'b0, "R1", "miso after deselect", int'(miso), 0);
    repeat (4) @(negedge clk);

    // R4 R5: fixed lengths 1..4 back to back under one select
    statusIn = 7'h5A;
    csLow();
    sendByte(8'h05, 8, -1);
    sendByte(8'h21, 8, -1);
    statusIn = 7'h33;
    sendByte(8'hC3, 8, -1);
    sendByte(8'h47, 8, -1);
    sendByte(8'h11, 8, -1);
    sendByte(8'h22, 8, -1);
    statusIn = 7'h0F;
    sendByte(8'h6A, 8, -1);
    sendByte(8'h80, 8, -1);
    sendByte(8'hFF, 8, -1);
    sendByte(8'h01, 8, -1);
    sendByte(8'h1E, 8, -1);
    csHigh();

    // R4: open-ended instruction runs until select rises
    statusIn = 7'h66;
    csLow();
    sendByte(8'hA5, 8, -1);
    for (int k = 0; k < 5; k++) sendByte(8'(8'h10 + 8'(k * 37)), 8, -1);
    csHigh();
    csLow();
    sendByte(8'h00, 8, -1);
    csHigh();

    // R7: long pauses inside bytes, oscillator flag low
    xoscStable = 1'b0;
    statusIn = 7'h2D;
    csLow();
    sendByte(8'h3C, 8, 3);
    sendByte(8'h96, 8, 6);
    csHigh();
    xoscStable = 1'b1;

    // R8: partial byte discarded when select rises
    csLow();
    sendByte(8'h90, 8, -1);
    sendByte(8'hFF, 3, -1);
    csHigh();
    csLow();
    sendByte(8'h12, 8, -1);
    csHigh();

    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R2", "bytes left undelivered", expQ.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule